// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management-side slave of a network transceiver. It watches a slow serial clock and a shared data line, both oversampled in the chip's system clock. It recognises management frames addressed to its own port number and gives read and write access to a bank of 32 sixteen-bit registers. Only a subset of the bank is backed by flip-flops. The rest reads as zero. During the data phase of a read the block drives the data line through an output enable. At every other time the line is left to the master.

Two bits of the bank are decoded for the datapath. The first is an isolate level that tells the MAC-facing outputs to go to high impedance. The management line keeps working while isolate is set. The second enables a link-drop hold flag, which is set by a link-down event and is held until software clears the enable bit. A hard disable input stops all register traffic and aborts any frame in progress.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive one bits. When fewer ones come before the start marker, the frame is ignored and has no effect on any register or on the data line.
- R2: Bits are sampled on the rising edge of the management clock, most significant bit first. The order after the preamble is: start marker 0 then 1, a two-bit op-code (1,0 = read, 0,1 = write), a 5-bit port address, a 5-bit register address, two turnaround bits, then 16 data bits. Any other op-code aborts the frame with no effect.
- R3: Frames are acted on only when the port address equals `phy_strap_i`. Other frames change no register and never cause the slave to drive the line.
- R4: A write stores its 16 data bits into registers 0 to 10, 15 and 16 to 21. All other addresses read back as 0 and ignore writes.
- R5: During a matched read, the output enable is low in the first turnaround bit period. In the second turnaround bit period the line is driven low. In each of the 16 following bit periods the next data bit is driven, MSB first, with each bit updated after a clock rising edge. The line is released in the bit period after the last data bit. During write frames the output enable stays low.
- R6: While `mgmt_dis_i` is high, reads are not driven and writes are not stored. Raising it during a frame releases the line and drops the frame. The next complete frame is handled normally.
- R7: `isolate_o` equals bit 10 of register 0.
- R8: When bit 2 of register 16 is set, a `link_down_i` pulse sets `link_hold_o`. The flag stays set while that bit stays 1, including across writes that keep it at 1. It clears when the bit is written to 0. A pulse while the bit is 0 has no effect.
- R9: After reset, all registers read 0 and `mdio_oe_o`, `isolate_o` and `link_hold_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the management signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_i | input | 1 | Management serial clock from the master |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data value driven onto the line during reads |
| mdio_oe_o | output | 1 | Output enable for the data line pad |
| phy_strap_i | input | 5 | Strapped port address this slave answers to |
| mgmt_dis_i | input | 1 | High blocks all accesses and aborts the current frame |
| link_down_i | input | 1 | One-cycle link-down event from the line side |
| isolate_o | output | 1 | Puts the MAC-facing datapath outputs into high impedance |
| link_hold_o | output | 1 | Sticky hold of MAC-side traffic after a link drop |

## Verification
The main write-then-read path is run over a table of data words and addresses. The words are alternating bit patterns, all ones, a single set MSB and LSB, and all zero. They are sent to implemented and unimplemented addresses, so that a stuck or shifted data bit shows up separately from a wrong address decode. Each read also checks the output-enable sequence bit by bit, which catches an off-by-one in the turnaround timing that a data compare alone would miss. Directed frames then vary one field at a time from a valid frame: a preamble one bit short, a foreign port address, an illegal op-code, and disable held high or raised mid-read. This shows that each check guards the frame on its own.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

  typedef enum logic [2:0] {
    S_PRE,
    S_ST,
    S_OP,
    S_PHY,
    S_REG,
    S_TA,
    S_DATA
  } mdio_st_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  // saturating counter step used for preamble counting
  function automatic int sat_inc(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  function automatic logic op_legal(input logic [1:0] op);
    return (op == OP_RD) || (op == OP_WR);
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic rise_o,
  output logic bit_o
);
  logic [STAGES-1:0] mdc_q;
  logic [STAGES-1:0] dat_q;
  logic              mdc_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q    <= '0;
      dat_q    <= '0;
      mdc_last <= 1'b0;
    end else begin
      mdc_q    <= {mdc_q[STAGES-2:0], mdc_i};
      dat_q    <= {dat_q[STAGES-2:0], mdio_i};
      mdc_last <= mdc_q[STAGES-1];
    end
  end

  assign rise_o = mdc_q[STAGES-1] & ~mdc_last;
  assign bit_o  = dat_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_parser.sv
module mdio_frame_parser
  import mdio_slv_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 5,
  parameter int PRE_LEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          bit_i,
  input  logic          dis_i,
  input  logic [AW-1:0] phy_strap_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          mdio_o,
  output logic          mdio_oe_o
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam int CW = $clog2(DW);

  mdio_st_e      st;
  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] bit_cnt;
  logic [1:0]    op;
  logic [AW-1:0] phy;
  logic [AW-1:0] rega;
  logic          hit;
  logic [DW-1:0] shreg;

  // named events for assertions
  logic is_rd, rd_go, last_data;
  assign is_rd     = (op == OP_RD);
  assign rd_go     = mdio_oe_o;
  assign last_data = (bit_cnt == CW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PRE;
      pre_cnt   <= '0;
      bit_cnt   <= '0;
      op        <= '0;
      phy       <= '0;
      rega      <= '0;
      hit       <= 1'b0;
      shreg     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (dis_i) begin
        st        <= S_PRE;
        pre_cnt   <= '0;
        mdio_oe_o <= 1'b0;
        mdio_o    <= 1'b0;
      end else if (rise_i) begin
        unique case (st)
          S_PRE: begin
            if (bit_i) pre_cnt <= PW'(sat_inc(int'(pre_cnt), PRE_LEN));
            else if (pre_cnt == PW'(PRE_LEN)) begin
              st      <= S_ST;
              pre_cnt <= '0;
            end else pre_cnt <= '0;
          end
          S_ST: begin
            bit_cnt <= '0;
            st      <= bit_i ? S_OP : S_PRE;
          end
          S_OP: begin
            op <= {op[0], bit_i};
            if (bit_cnt == CW'(1)) begin
              bit_cnt <= '0;
              st      <= op_legal({op[0], bit_i}) ? S_PHY : S_PRE;
            end else bit_cnt <= bit_cnt + 1'b1;
          end
          S_PHY: begin
            phy <= {phy[AW-2:0], bit_i};
            if (bit_cnt == CW'(AW - 1)) begin
              bit_cnt <= '0;
              st      <= S_REG;
            end else bit_cnt <= bit_cnt + 1'b1;
          end
          S_REG: begin
            rega <= {rega[AW-2:0], bit_i};
            if (bit_cnt == CW'(AW - 1)) begin
              bit_cnt <= '0;
              hit     <= (phy == phy_strap_i);
              st      <= S_TA;
            end else bit_cnt <= bit_cnt + 1'b1;
          end
          S_TA: begin
            if (bit_cnt == '0) begin
              bit_cnt <= CW'(1);
              if (is_rd && hit) begin
                mdio_oe_o <= 1'b1;
                mdio_o    <= 1'b0;
                shreg     <= rd_data_i;
              end else if (!is_rd && !bit_i) st <= S_PRE;
            end else if (!is_rd && bit_i) begin
              st <= S_PRE;
            end else begin
              st      <= S_DATA;
              bit_cnt <= '0;
              if (rd_go) begin
                mdio_o <= shreg[DW-1];
                shreg  <= {shreg[DW-2:0], 1'b0};
              end
            end
          end
          S_DATA: begin
            if (rd_go) begin
              mdio_o <= shreg[DW-1];
              shreg  <= {shreg[DW-2:0], 1'b0};
            end else shreg <= {shreg[DW-2:0], bit_i};
            if (last_data) begin
              st        <= S_PRE;
              mdio_oe_o <= 1'b0;
              mdio_o    <= 1'b0;
              if (!is_rd && hit) begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= rega;
                wr_data_o <= {shreg[DW-2:0], bit_i};
              end
            end else bit_cnt <= bit_cnt + 1'b1;
          end
          default: st <= S_PRE;
        endcase
      end
    end
  end

  assign rd_addr_o = rega;

  // R1
  pre_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ST && $past(st) == S_PRE) |-> $past(pre_cnt) == PW'(PRE_LEN));

  // R5
  oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe_o |-> (st == S_TA || st == S_DATA));

  // R6
  dis_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |=> (!mdio_oe_o && !wr_en_o));

  // R2
  write_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> op == OP_WR);
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
  parameter int              DW        = 16,
  parameter int              NREG      = 32,
  parameter logic [NREG-1:0] IMPL_MASK = 32'h003F_87FF,
  parameter int              ISO_REG   = 0,
  parameter int              ISO_BIT   = 10,
  parameter int              HOLD_REG  = 16,
  parameter int              HOLD_BIT  = 2,
  localparam int             AW        = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          iso_bit_o,
  output logic          hold_en_o
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (IMPL_MASK[g]) begin : g_impl
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en_i && wr_addr_i == AW'(g)) q <= wr_data_i;
      end
      assign regs[g] = q;
    end else begin : g_none
      assign regs[g] = '0;
    end
  end

  assign rd_data_o = IMPL_MASK[rd_addr_i] ? regs[rd_addr_i] : '0;
  assign iso_bit_o = regs[ISO_REG][ISO_BIT];
  assign hold_en_o = regs[HOLD_REG][HOLD_BIT];

  // R4
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && IMPL_MASK[wr_addr_i]) |=> regs[$past(wr_addr_i)] == $past(wr_data_i));

  // R4
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !IMPL_MASK[rd_addr_i] |-> rd_data_o == '0);
endmodule

// File: rtl/mdio_ctl_decode.sv
module mdio_ctl_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic iso_bit_i,
  input  logic hold_en_i,
  input  logic link_down_i,
  output logic isolate_o,
  output logic link_hold_o
);
  assign isolate_o = iso_bit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            link_hold_o <= 1'b0;
    else if (!hold_en_i)   link_hold_o <= 1'b0;
    else if (link_down_i)  link_hold_o <= 1'b1;
  end

  // R8
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_hold_o) |-> $past(hold_en_i && link_down_i));

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_hold_o && hold_en_i) |=> link_hold_o);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          NREG      = 32,
  parameter int          PRE_LEN   = 32,
  parameter int          SYNC      = 2,
  parameter logic [31:0] IMPL_MASK = 32'h003F_87FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mdc_i,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe_o,
  input  logic [4:0] phy_strap_i,
  input  logic       mgmt_dis_i,
  input  logic       link_down_i,
  output logic       isolate_o,
  output logic       link_hold_o
);
  localparam int AW = $clog2(NREG);

  logic          rise, sbit;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en, iso_bit, hold_en;

  mdio_edge_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_i(mdio_i),
    .rise_o(rise), .bit_o(sbit)
  );

  mdio_frame_parser #(.DW(DW), .AW(AW), .PRE_LEN(PRE_LEN)) u_parse (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .bit_i(sbit), .dis_i(mgmt_dis_i),
    .phy_strap_i(phy_strap_i), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  mdio_reg_bank #(.DW(DW), .NREG(NREG), .IMPL_MASK(IMPL_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .iso_bit_o(iso_bit), .hold_en_o(hold_en)
  );

  mdio_ctl_decode u_ctl (
    .clk(clk), .rst_n(rst_n), .iso_bit_i(iso_bit), .hold_en_i(hold_en),
    .link_down_i(link_down_i), .isolate_o(isolate_o), .link_hold_o(link_hold_o)
  );

  // R7
  iso_no_mdio_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isolate_o && wr_en == 1'b0 && $past(rise) == 1'b0 && $past(mgmt_dis_i) == 1'b0)
      |-> $stable(mdio_oe_o));
endmodule

// File: tb/mdio_mgmt_slave_test.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_test;
  localparam int H = 8;
  localparam logic [4:0] STRAP = 5'h0B;

  logic clk = 0, rst_n = 0;
  logic mdc = 0, mdio_in = 0, dis = 0, ldn = 0;
  logic [4:0] strap = STRAP;
  logic mdio_out, oe, iso, hold;
  logic s_oe, s_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mdio_mgmt_slave uut (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_i(mdio_in),
    .mdio_o(mdio_out), .mdio_oe_o(oe), .phy_strap_i(strap),
    .mgmt_dis_i(dis), .link_down_i(ldn), .isolate_o(iso), .link_hold_o(hold)
  );

  // {register address, write data, expected readback}
  localparam logic [36:0] VEC [7] = '{
    {5'd1,  16'hA5A5, 16'hA5A5},
    {5'd21, 16'hFFFF, 16'hFFFF},
    {5'd15, 16'h8001, 16'h8001},
    {5'd11, 16'h1234, 16'h0000},
    {5'd31, 16'hBEEF, 16'h0000},
    {5'd10, 16'h5A5A, 16'h5A5A},
    {5'd5,  16'h0000, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_per(input logic b);
    mdio_in = b;
    mdc = 0;
    repeat (H) @(negedge clk);
    s_oe = oe;
    s_out = mdio_out;
    mdc = 1;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame(input int pre_len, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rd, output logic seq_ok, output logic any_oe);
    logic rdop;
    rdop = (op == 2'b10);
    rd = '0; seq_ok = 1; any_oe = 0;
    for (int i = 0; i < pre_len; i++) begin bit_per(1); any_oe |= s_oe; end
    bit_per(0); any_oe |= s_oe;
    bit_per(1); any_oe |= s_oe;
    for (int i = 1; i >= 0; i--) begin bit_per(op[i]); any_oe |= s_oe; end
    for (int i = 4; i >= 0; i--) begin bit_per(phy[i]); any_oe |= s_oe; end
    for (int i = 4; i >= 0; i--) begin bit_per(ra[i]); any_oe |= s_oe; end
    bit_per(1);
    if (s_oe) seq_ok = 0;
    any_oe |= s_oe;
    bit_per(rdop ? 1'b1 : 1'b0);
    if (!(s_oe && !s_out)) seq_ok = 0;
    any_oe |= s_oe;
    for (int i = 15; i >= 0; i--) begin
      bit_per(rdop ? 1'b1 : wd[i]);
      rd[i] = s_out;
      if (!s_oe) seq_ok = 0;
      any_oe |= s_oe;
    end
    bit_per(0);
    if (s_oe) seq_ok = 0;
    any_oe |= s_oe;
  endtask

  task automatic wr(input logic [4:0] ra, input logic [15:0] wd, output logic any_oe);
    logic [15:0] d; logic ok;
    frame(32, 2'b01, STRAP, ra, wd, d, ok, any_oe);
  endtask

  task automatic rdr(input logic [4:0] ra, output logic [15:0] d, output logic ok);
    logic a;
    frame(32, 2'b10, STRAP, ra, 16'h0, d, ok, a);
  endtask

  task automatic pulse_ldn();
    ldn = 1; @(negedge clk); ldn = 0; repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d; logic ok, a;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk(oe == 0 && iso == 0 && hold == 0, "R9 outputs after reset", {oe, iso, hold}, 0);
    rdr(5'd0, d, ok);
    chk(d == 16'h0 && ok, "R9 reg0 after reset", d, 0);
    rdr(5'd16, d, ok);
    chk(d == 16'h0, "R9 reg16 after reset", d, 0);

    // R4 R5 table of write/read vectors
    foreach (VEC[k]) begin
      wr(VEC[k][36:32], VEC[k][31:16], a);
      chk(!a, "R5 no drive during write", a, 0);
      rdr(VEC[k][36:32], d, ok);
      chk(d == VEC[k][15:0], "R4 readback", d, VEC[k][15:0]);
      chk(ok, "R5 turnaround/data enable sequence", ok, 1);
    end

    // R3 foreign port address
    frame(32, 2'b01, 5'h0C, 5'd2, 16'h1111, d, ok, a);
    rdr(5'd2, d, ok);
    chk(d == 16'h0, "R3 foreign write ignored", d, 0);
    frame(32, 2'b10, 5'h0C, 5'd1, 16'h0, d, ok, a);
    chk(!a, "R3 foreign read not driven", a, 0);

    // R1 short preamble
    frame(31, 2'b01, STRAP, 5'd3, 16'h3333, d, ok, a);
    rdr(5'd3, d, ok);
    chk(d == 16'h0, "R1 31-bit preamble ignored", d, 0);
    frame(31, 2'b10, STRAP, 5'd1, 16'h0, d, ok, a);
    chk(!a, "R1 short preamble read not driven", a, 0);

    // R2 illegal op-code
    frame(32, 2'b11, STRAP, 5'd4, 16'h4444, d, ok, a);
    rdr(5'd4, d, ok);
    chk(d == 16'h0, "R2 op-code 11 ignored", d, 0);

    // R6 disable
    dis = 1;
    wr(5'd5, 16'h5555, a);
    frame(32, 2'b10, STRAP, 5'd1, 16'h0, d, ok, a);
    chk(!a, "R6 read not driven while disabled", a, 0);
    dis = 0;
    rdr(5'd5, d, ok);
    chk(d == 16'h0, "R6 write blocked while disabled", d, 0);
    // disable raised mid-read
    for (int i = 0; i < 32; i++) bit_per(1);
    bit_per(0); bit_per(1); bit_per(1); bit_per(0);
    for (int i = 4; i >= 0; i--) bit_per(STRAP[i]);
    for (int i = 4; i >= 0; i--) bit_per(i == 0);
    bit_per(1); bit_per(1); bit_per(1);
    chk(s_oe == 1, "R5 enable up in read data", s_oe, 1);
    dis = 1;
    bit_per(1);
    chk(s_oe == 0, "R6 disable releases line", s_oe, 0);
    dis = 0;
    rdr(5'd1, d, ok);
    chk(d == 16'hA5A5 && ok, "R6 next frame after abort", d, 16'hA5A5);

    // R7 isolate
    wr(5'd0, 16'h0400, a);
    chk(iso == 1, "R7 isolate set", iso, 1);
    rdr(5'd1, d, ok);
    chk(d == 16'hA5A5 && ok, "R7 management works while isolated", d, 16'hA5A5);
    wr(5'd0, 16'h0000, a);
    chk(iso == 0, "R7 isolate cleared", iso, 0);

    // R8 link-drop hold
    pulse_ldn();
    chk(hold == 0, "R8 pulse without enable", hold, 0);
    wr(5'd16, 16'h0004, a);
    chk(hold == 0, "R8 enable alone", hold, 0);
    pulse_ldn();
    chk(hold == 1, "R8 hold set", hold, 1);
    wr(5'd16, 16'h0005, a);
    chk(hold == 1, "R8 hold kept on write with bit 1", hold, 1);
    wr(5'd16, 16'h0000, a);
    chk(hold == 0, "R8 hold cleared", hold, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule